// File: doc/BRIEF.md
# Clock Bank Disable Gate

This block sits between the clock generator of one output bank and its pad drivers. Every output of the bank is the bank clock, taken either as it is or inverted. For each output the block produces a data level and an active-high output enable. The whole design runs on a fast sampling clock. The bank clock arrives as a level sampled in that domain.

A single disable request and a three-level output-mode code control the bank. The disable request is asynchronous and passes through a two-stage synchroniser. In tri-state mode, a disable drops every output enable. In hold-off mode the enables stay high and each output is parked at its idle level. The park happens only while that output already rests at the idle level, so no pulse is cut short. On release, an output starts again only when the bank clock moves away from idle. In test mode the disable request is ignored and a test flag is raised.

Top module: `bank_gate_top`

## Requirements
- R1: After reset, every output enable is 1, every data output is 0 and the test flag is 0.
- R2: While the outputs are enabled, each data output equals the bank clock XOR that output's invert bit, as sampled at the previous rising edge of the sampling clock (one cycle of latency).
- R3: With output mode 2'b10 (tri-state), raising the disable request drops all output enables on the third rising edge after the change. Lowering it raises them again on the third rising edge.
- R4: With output mode 2'b00 (hold-off), a disabled output whose invert bit is 0 rests at 0, and one whose invert bit is 1 rests at 1.
- R5: In hold-off, every output has parked by the rising edge 3+H after the request changes, where H is the half period of the bank clock in sampling cycles. This is well within six bank clock periods.
- R6: In hold-off mode the output enables stay 1 whether or not the disable request is set.
- R7: Parking and release never produce a level segment shorter than the bank clock half period. Release takes effect only at a bank clock transition away from the idle level.
- R8: With output mode 2'b01 or 2'b11 (test), the disable request has no effect: enables stay 1, data follows R2, and the test flag is 1 from the next rising edge.
- R9: The test flag is 0 in modes 2'b00 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bank_clk_i | input | 1 | Bank clock level from the generator |
| inv_i | input | NOUT | Per-output invert select (static) |
| dis_i | input | 1 | Asynchronous bank disable request |
| mode_i | input | 2 | Output mode: 00 hold-off, 10 tri-state, 01/11 test |
| dat_o | output | NOUT | Per-output data level |
| oe_o | output | NOUT | Per-output enable, active high |
| test_o | output | 1 | Test mode flag |

## Verification
Data outputs are due one sampling edge after the bank clock level they reflect. The monitor captures that level at each rising edge and compares shortly afterwards. Enable changes are due on the third edge after a disable change, so the bench checks one edge before that point and at it. Hold-off parking is checked from edge 3+H on, and data following resumes 3+2H edges after release. A separate monitor measures every level segment against H.

// File: rtl/bank_gate_pkg.sv
package bank_gate_pkg;
  typedef enum logic [1:0] {
    MODE_PARK  = 2'b00,
    MODE_TEST  = 2'b01,
    MODE_TRIZ  = 2'b10,
    MODE_TEST2 = 2'b11
  } out_mode_e;

  function automatic logic is_test(input logic [1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/bank_gate_sync.sv
module bank_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bank_gate_lane.sv
module bank_gate_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph_i,
  input  logic ph_prev_i,
  input  logic inv_i,
  input  logic stop_i,
  output logic dat_o
);
  logic run_q, run_d;
  logic dat_q, dat_d;
  logic cur_lvl, prev_lvl, idle_lvl;

  always_comb begin
    idle_lvl = inv_i;
    cur_lvl  = ph_i ^ inv_i;
    prev_lvl = ph_prev_i ^ inv_i;
    if (run_q) run_d = !(stop_i && (cur_lvl == idle_lvl));
    else       run_d = !stop_i && (prev_lvl == idle_lvl) && (cur_lvl != idle_lvl);
    dat_d = (run_q || run_d) ? cur_lvl : dat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b1;
      dat_q <= 1'b0;
    end else begin
      run_q <= run_d;
      dat_q <= dat_d;
    end
  end

  assign dat_o = dat_q;

  // R4: a parked lane keeps its level
  p_park_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !run_d) |=> $stable(dat_q));
  // R7: a release always coincides with a transition of the lane output
  p_release_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> (dat_q != $past(dat_q)));
endmodule

// File: rtl/bank_gate_top.sv
module bank_gate_top #(
  parameter int NOUT      = 4,
  parameter int SYNC_STGS = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bank_clk_i,
  input  logic [NOUT-1:0] inv_i,
  input  logic            dis_i,
  input  logic [1:0]      mode_i,
  output logic [NOUT-1:0] dat_o,
  output logic [NOUT-1:0] oe_o,
  output logic            test_o
);
  import bank_gate_pkg::*;

  localparam logic [NOUT-1:0] ALL_ON = {NOUT{1'b1}};

  logic dis_s;
  logic ph_prev_q;
  logic oe_q, oe_d;
  logic test_q, test_d;
  logic stop;

  bank_gate_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dis_i),
    .q_o   (dis_s)
  );

  always_comb begin
    stop   = dis_s && (mode_i == MODE_PARK);
    oe_d   = !(dis_s && (mode_i == MODE_TRIZ));
    test_d = is_test(mode_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_prev_q <= 1'b0;
      oe_q      <= 1'b1;
      test_q    <= 1'b0;
    end else begin
      ph_prev_q <= bank_clk_i;
      oe_q      <= oe_d;
      test_q    <= test_d;
    end
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_lane
    bank_gate_lane u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ph_i     (bank_clk_i),
      .ph_prev_i(ph_prev_q),
      .inv_i    (inv_i[k]),
      .stop_i   (stop),
      .dat_o    (dat_o[k])
    );
  end

  assign oe_o   = {NOUT{oe_q}};
  assign test_o = test_q;

  // R6: hold-off mode never tri-states
  p_park_keeps_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PARK && $past(mode_i) == MODE_PARK) |-> (oe_o == ALL_ON));
  // R8: test flag implies enabled outputs
  p_test_enabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_o |-> (oe_o == ALL_ON));
endmodule

// File: tb/bank_gate_top_bench.sv
module bank_gate_top_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ph = 1'b0;
  logic [N-1:0] inv = '0;
  logic         dis = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [N-1:0] dat, oe;
  logic         tst;

  int checks = 0;
  int errors = 0;
  int half = 2;
  int hc = 0;
  bit follow_on = 0;
  bit runt_on = 0;
  int wid [N];
  logic [N-1:0] last_dat = '0;

  bank_gate_top u_bank_gate_top (
    .clk_i(clk), .rst_ni(rst_n), .bank_clk_i(ph), .inv_i(inv),
    .dis_i(dis), .mode_i(mode), .dat_o(dat), .oe_o(oe), .test_o(tst)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (hc >= half - 1) begin ph <= ~ph; hc <= 0; end
    else hc <= hc + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] expect_follow(input logic p, input logic [N-1:0] iv);
    return {N{p}} ^ iv;
  endfunction

  // monitor: data following (R2) and segment widths (R7)
  always @(posedge clk) begin
    logic phs;
    phs = ph;
    #1;
    if (follow_on) chk(dat == expect_follow(phs, inv), "R2", dat, expect_follow(phs, inv));
    for (int k = 0; k < N; k++) begin
      if (dat[k] != last_dat[k]) begin
        if (runt_on && wid[k] < half) chk(1'b0, "R7", wid[k], half);
        wid[k] = 1;
      end else wid[k] = wid[k] + 1;
    end
    last_dat = dat;
  end

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_half(input int h);
    follow_on = 0; runt_on = 0;
    @(negedge clk); half = h;
    edges(4 * h + 4);
    for (int k = 0; k < N; k++) wid[k] = h;
    runt_on = 1;
  endtask

  task automatic triz_case;
    @(negedge clk); mode = 2'b10; follow_on = 1;
    edges(3);
    @(negedge clk); dis = 1;
    edges(2);
    chk(oe == '1, "R3", oe, '1);
    edges(1);
    chk(oe == '0, "R3", oe, '0);
    chk(tst == 0, "R9", tst, 0);
    @(negedge clk); dis = 0;
    edges(2);
    chk(oe == '0, "R3", oe, '0);
    edges(1);
    chk(oe == '1, "R3", oe, '1);
  endtask

  task automatic park_case(input int pre);
    @(negedge clk); mode = 2'b00; follow_on = 1;
    edges(pre);
    @(negedge clk); dis = 1; follow_on = 0;
    edges(3 + half + 1);
    for (int c = 0; c < 4 * half; c++) begin
      chk(dat == inv, "R4", dat, inv);
      chk(oe == '1, "R6", oe, '1);
      edges(1);
    end
    chk(dat == inv, "R5", dat, inv);
    chk(tst == 0, "R9", tst, 0);
    @(negedge clk); dis = 0;
    edges(3 + 2 * half + 1);
    follow_on = 1;
    edges(2 * half + 2);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < N; k++) wid[k] = 0;
    edges(2);
    chk(oe == '1, "R1", oe, '1);
    chk(dat == '0, "R1", dat, '0);
    chk(tst == 0, "R1", tst, 0);
    @(negedge clk); rst_n = 1;
    edges(2);

    // directed: mixed polarity, short and long half periods
    inv = 4'b1010;
    set_half(1);
    follow_on = 1; edges(20);
    park_case(0);
    triz_case();
    set_half(5);
    park_case(3);

    // random
    for (int it = 0; it < 24; it++) begin
      inv = N'($urandom);
      set_half(1 + int'($urandom % 6));
      if ($urandom % 3 == 0) triz_case();
      else park_case(int'($urandom % 13));
    end

    // test mode: disable ignored (R8)
    @(negedge clk); mode = 2'b01; dis = 1; follow_on = 1;
    edges(1);
    chk(tst == 1, "R8", tst, 1);
    for (int c = 0; c < 20; c++) begin
      chk(oe == '1, "R8", oe, '1);
      edges(1);
    end
    @(negedge clk); mode = 2'b11;
    edges(3);
    chk(tst == 1, "R8", tst, 1);
    chk(oe == '1, "R8", oe, '1);
    @(negedge clk); mode = 2'b10; dis = 0;
    edges(1);
    chk(tst == 0, "R9", tst, 0);
    edges(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule